// File: doc/BRIEF.md
# Timer Event Flag Unit

This unit collects four timer events into one byte of sticky status flags. A free-running counter reports every wrap from all ones to zero. A prescaler produces a periodic tick whose period is chosen by a two-bit rate code. Two external single-cycle event inputs report pulse-accumulator overflow and pulse-accumulator input edges. The flags occupy the upper nibble of a status byte. A mask byte with the same bit layout decides which of them drive the interrupt line. Software can therefore either poll the flags or take interrupts.

Software reaches the unit over a small byte-wide register bus with a two-bit address. Flags are cleared by writing ones to their positions, and zeros leave them unchanged. Writing the rate code also restarts the prescaler, so the first tick after the write arrives exactly one full period later. The counter value is available on a port as a read-only value.

Top module: `tmr_evt_flags`

## Requirements
- R1: After reset `cnt_val` is 0. It increments by one on every clock and wraps from all ones to 0.
- R2: Flag bit 7 of the status byte sets on the clock edge where `cnt_val` goes from all ones to 0, and not before.
- R3: Flag bit 6 sets every 2^(RTI_BASE_LOG2 + rate) clocks. `rate` is bits [1:0] of the control byte at address 2. A write to address 2 restarts the period, so the tick falls 2^(RTI_BASE_LOG2 + rate) edges after the writing edge.
- R4: A one-cycle high on `pa_ovf_evt` sets flag bit 5. A one-cycle high on `pa_edge_evt` sets flag bit 4.
- R5: Writing the status byte at address 0 clears each flag whose data bit is 1. A 0 data bit leaves that flag unchanged.
- R6: If an event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R7: Bits [3:0] read 0 from the status byte (address 0) and from the mask byte (address 1). Bits [7:2] of the control byte read 0. Address 3 reads 0x00.
- R8: After reset all flags, the mask and the rate code are 0, and `irq` and `bus_rdata` are 0.
- R9: `irq` is the OR over bits [7:4] of each flag ANDed with the mask bit in the same position. It is registered and follows the flags and mask with one cycle of delay.
- R10: `bus_rdata` is registered. It shows the register selected by `bus_addr` on the edge before, taken from the register values held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 status, 1 mask, 2 control, 3 none |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pa_ovf_evt | input | 1 | Pulse-accumulator overflow event, one cycle |
| pa_edge_evt | input | 1 | Pulse-accumulator input-edge event, one cycle |
| cnt_val | output | CNT_W | Free-running counter value |
| irq | output | 1 | Registered masked interrupt request |

## Verification
The hardest case to reach from the ports is a clearing write that lands in the same cycle as an event on the same flag. The wrap and tick events arrive on their own schedule, so the bench uses the pulse-accumulator inputs for this case: it raises `pa_edge_evt` in the very cycle that carries the write of a one to bit 4. The tick period is measured from the rate write to the rise of `irq`, with only bit 6 unmasked, for every rate code. The wrap flag is followed through the registered read port across the cycles on either side of the counter rollover.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam logic [1:0] ADDR_FLAG = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_CTL  = 2'd2;

  localparam int NUM_EVT = 4;
  // event order inside the upper nibble, index 3 maps to byte bit 7
  localparam int EVT_WRAP = 3;
  localparam int EVT_TICK = 2;
  localparam int EVT_PAOV = 1;
  localparam int EVT_PAED = 0;

  typedef logic [NUM_EVT-1:0] evt_vec_t;
endpackage

// File: rtl/tmr_free_cnt.sv
module tmr_free_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  // the next edge takes the counter from all ones to zero
  assign wrap = &cnt;

  p_wrap_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (cnt == {CNT_W{1'b1}}) |=> (cnt == '0));
endmodule

// File: rtl/tmr_rti_tick.sv
module tmr_rti_tick #(
  parameter int RTI_BASE_LOG2 = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rate_we,
  input  logic [1:0] rate_wd,
  output logic [1:0] rate,
  output logic       tick
);
  localparam int PRE_W = RTI_BASE_LOG2 + 3;

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] lim;

  always_ff @(posedge clk) begin
    if (rst) begin
      rate <= '0;
      pre  <= '0;
    end else if (rate_we) begin
      rate <= rate_wd;
      pre  <= '0;
    end else begin
      pre  <= pre + 1'b1;
    end
  end

  // RTI_BASE_LOG2 + rate low-order ones
  always_comb lim = {PRE_W{1'b1}} >> (2'd3 - rate);

  assign tick = ((pre & lim) == lim) && !rate_we;

  p_tick_single_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  p_restart_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    rate_we |=> !tick);
endmodule

// File: rtl/tmr_flag_bank.sv
module tmr_flag_bank
  import tmr_evt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  evt_vec_t evt_set,
  input  evt_vec_t evt_clr,
  input  logic     mask_we,
  input  evt_vec_t mask_wd,
  output evt_vec_t flags,
  output evt_vec_t mask,
  output logic     irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      mask  <= '0;
      irq   <= 1'b0;
    end else begin
      // a set in the same cycle overrides the clear
      flags <= (flags & ~evt_clr) | evt_set;
      if (mask_we) mask <= mask_wd;
      irq   <= |(flags & mask);
    end
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_chk
    p_evt_sets_r6: assert property (@(posedge clk) disable iff (rst)
      evt_set[i] |=> flags[i]);
    p_clear_only_w1c_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(flags[i]) |-> $past(evt_clr[i]));
  end

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !irq);
endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags
  import tmr_evt_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int RTI_BASE_LOG2 = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       bus_addr,
  input  logic             bus_we,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             pa_ovf_evt,
  input  logic             pa_edge_evt,
  output logic [CNT_W-1:0] cnt_val,
  output logic             irq
);
  logic     wrap_evt;
  logic     tick_evt;
  logic [1:0] rate;
  evt_vec_t flags;
  evt_vec_t mask;
  evt_vec_t evt_set;
  evt_vec_t evt_clr;
  logic     wr_flag;
  logic     wr_mask;
  logic     wr_ctl;
  logic     wdata_unused;

  assign wr_flag = bus_we && (bus_addr == ADDR_FLAG);
  assign wr_mask = bus_we && (bus_addr == ADDR_MASK);
  assign wr_ctl  = bus_we && (bus_addr == ADDR_CTL);
  assign wdata_unused = ^bus_wdata[3:2];

  tmr_free_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .cnt  (cnt_val),
    .wrap (wrap_evt)
  );

  tmr_rti_tick #(.RTI_BASE_LOG2(RTI_BASE_LOG2)) u_rti (
    .clk     (clk),
    .rst     (rst),
    .rate_we (wr_ctl),
    .rate_wd (bus_wdata[1:0]),
    .rate    (rate),
    .tick    (tick_evt)
  );

  always_comb begin
    evt_set           = '0;
    evt_set[EVT_WRAP] = wrap_evt;
    evt_set[EVT_TICK] = tick_evt;
    evt_set[EVT_PAOV] = pa_ovf_evt;
    evt_set[EVT_PAED] = pa_edge_evt;
    evt_clr           = wr_flag ? bus_wdata[7:4] : '0;
  end

  tmr_flag_bank u_flags (
    .clk     (clk),
    .rst     (rst),
    .evt_set (evt_set),
    .evt_clr (evt_clr),
    .mask_we (wr_mask),
    .mask_wd (bus_wdata[7:4]),
    .flags   (flags),
    .mask    (mask),
    .irq     (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (bus_addr)
        ADDR_FLAG: bus_rdata <= {flags, 4'b0000};
        ADDR_MASK: bus_rdata <= {mask, 4'b0000};
        ADDR_CTL:  bus_rdata <= {6'b000000, rate};
        default:   bus_rdata <= 8'h00;
      endcase
    end
  end

  p_low_nibble_zero_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) != ADDR_CTL) |-> (bus_rdata[3:0] == 4'h0));
  p_ctl_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == ADDR_CTL) |-> (bus_rdata[7:2] == 6'h00));
endmodule

// File: tb/tmr_evt_flags_bench.sv
`timescale 1ns/1ps
module tmr_evt_flags_bench;
  localparam int CNT_W = 8;
  localparam int BASE  = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       bus_addr = 2'd0;
  logic             bus_we = 1'b0;
  logic [7:0]       bus_wdata = 8'h00;
  logic [7:0]       bus_rdata;
  logic             pa_ovf_evt = 1'b0;
  logic             pa_edge_evt = 1'b0;
  logic [CNT_W-1:0] cnt_val;
  logic             irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  tmr_evt_flags #(.CNT_W(CNT_W), .RTI_BASE_LOG2(BASE)) u_tmr_evt_flags (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pa_ovf_evt(pa_ovf_evt),
    .pa_edge_evt(pa_edge_evt), .cnt_val(cnt_val), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    step();
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    step();
    d = bus_rdata;
  endtask

  task automatic pulse(input logic ovf, input logic edg);
    pa_ovf_evt = ovf; pa_edge_evt = edg;
    step();
    pa_ovf_evt = 1'b0; pa_edge_evt = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [CNT_W-1:0] prev;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R8 reset state
    chk("R8 cnt", int'(cnt_val), 0);
    chk("R8 irq", int'(irq), 0);
    chk("R8 rdata", int'(bus_rdata), 0);
    bus_read(2'd0, rd); chk("R8 flags", int'(rd), 0);
    bus_read(2'd1, rd); chk("R8 mask", int'(rd), 0);
    bus_read(2'd2, rd); chk("R8 rate", int'(rd), 0);

    // R1 counter steps every clock across two wraps
    prev = cnt_val;
    for (int i = 0; i < 600; i++) begin
      step();
      chk("R1 step", int'(cnt_val), int'(CNT_W'(prev + 1'b1)));
      prev = cnt_val;
    end

    // R7 / R10 read-back layout
    bus_write(2'd1, 8'hFF); bus_read(2'd1, rd); chk("R7 mask FF", int'(rd), 8'hF0);
    bus_write(2'd1, 8'hA5); bus_read(2'd1, rd); chk("R7 mask A5", int'(rd), 8'hA0);
    bus_write(2'd2, 8'hFF); bus_read(2'd2, rd); chk("R7 ctl FF", int'(rd), 8'h03);
    bus_read(2'd3, rd); chk("R7 addr3", int'(rd), 0);
    bus_write(2'd0, 8'h0F); bus_read(2'd0, rd); chk("R7 flag low", int'(rd[3:0]), 0);

    // R3 tick period for every rate, seen on irq with only bit 6 unmasked
    bus_write(2'd1, 8'h40);
    for (int r = 0; r < 4; r++) begin
      bus_write(2'd2, 8'(r));
      bus_write(2'd0, 8'h40);
      step();
      n = 2;
      while (!irq && n < 2000) begin step(); n++; end
      chk($sformatf("R3 period rate %0d", r), n, (1 << (BASE + r)) + 1);
      bus_read(2'd2, rd); chk("R3 rate readback", int'(rd), r);
    end

    // R2 wrap flag around rollover
    bus_write(2'd1, 8'h00);
    while (cnt_val != 10) step();
    bus_write(2'd0, 8'h80);
    bus_addr = 2'd0;
    while (cnt_val != CMAX) step();
    chk("R2 before wrap", int'(bus_rdata[7]), 0);
    step();
    chk("R2 at zero", int'(bus_rdata[7]), 0);
    step();
    chk("R2 after wrap", int'(bus_rdata[7]), 1);

    // R4 / R5 pulse flags and write-one-to-clear
    bus_write(2'd0, 8'h30);
    bus_read(2'd0, rd); chk("R5 cleared", int'(rd[5:4]), 0);
    pulse(1'b1, 1'b0);
    bus_read(2'd0, rd); chk("R4 ovf only", int'(rd[5:4]), 2'b10);
    pulse(1'b0, 1'b1);
    bus_read(2'd0, rd); chk("R4 both", int'(rd[5:4]), 2'b11);
    bus_write(2'd0, 8'h0F);
    bus_read(2'd0, rd); chk("R5 zero keeps", int'(rd[5:4]), 2'b11);
    bus_write(2'd0, 8'h10);
    bus_read(2'd0, rd); chk("R5 clear bit4", int'(rd[5:4]), 2'b10);
    bus_write(2'd0, 8'h20);
    bus_read(2'd0, rd); chk("R5 clear bit5", int'(rd[5:4]), 2'b00);

    // R6 event in the same cycle as a clearing write
    pa_edge_evt = 1'b1;
    bus_write(2'd0, 8'h10);
    pa_edge_evt = 1'b0;
    bus_read(2'd0, rd); chk("R6 event wins", int'(rd[4]), 1);

    // R9 mask sweep with all four flags set
    bus_write(2'd2, 8'h00);
    repeat (300) step();
    pulse(1'b1, 1'b1);
    bus_read(2'd0, rd); chk("R9 all flags", int'(rd), 8'hF0);
    for (int m = 0; m < 16; m++) begin
      bus_write(2'd1, 8'(m << 4));
      step();
      chk($sformatf("R9 all set mask %0d", m), int'(irq), int'(m != 0));
    end
    // only wrap and tick flags left set
    bus_write(2'd0, 8'h30);
    for (int m = 0; m < 16; m++) begin
      bus_write(2'd1, 8'(m << 4));
      step();
      chk($sformatf("R9 upper mask %0d", m), int'(irq), int'((m & 12) != 0));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule